// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back, write-allocate data cache built from a direct-mapped line array and a small fully associative buffer that keeps lines recently pushed out of that array. A processor issues word reads and writes through a valid/ready handshake. A request that hits the line array is accepted in the cycle it is presented, and read data follows one cycle later. A request that misses raises a stall. The cache then looks in the victim buffer. If the line is there, the cache exchanges it with the resident line without any memory traffic. Otherwise the cache moves the resident line into a buffer slot and fetches the block from memory. When the cache returns to idle, the held request is evaluated again.

The memory side moves whole blocks in one transfer. A request carries a block address, a write flag and, for writes, the block data. A read completes when a one-cycle response carrying the block arrives. The victim buffer cuts conflict misses between addresses that share an index, and it leaves the single-cycle hit path of the direct-mapped array unchanged.

Top module: `cvb_cache`

## Requirements
- R1: After reset every line and every victim slot is invalid. The stall output, the memory request and the read response are low, and the first access to any block is fetched from memory.
- R2: The word address splits from the bottom up. Bits [1:0] select the word within a 4-word block, bits [4:2] select one of 8 lines, and the rest is the tag. The block address sent to memory is the word address shifted right by 2.
- R3: A request that hits the line array is accepted in the cycle it is presented, with no stall and no memory transfer. Read data appears with the read response one cycle after acceptance.
- R4: When a request misses both the line array and the victim buffer, stall goes high and exactly one block read is issued. The request is then accepted and completes with the fetched data.
- R5: A write hit changes only the cached copy and produces no memory write. A write miss first fetches the block and then merges the written word into it.
- R6: A valid line displaced by a fetch is placed into a victim slot and is not written to memory at that point.
- R7: A request that hits a victim slot causes no memory transfer. The requested line moves into the line array, and the displaced line takes over the freed slot with its block address and dirty state kept.
- R8: Fetches fill the victim slots in round-robin order starting at slot 0 after reset. If the slot about to be reused holds a dirty line, that line is written to memory before the fetch. The write carries the line's block address and all four words, with word w at bits [32w+31:32w]. A clean slot is overwritten without a write.
- R9: A memory request keeps its valid, write flag and block address unchanged until ready is seen.
- R10: The read response is high exactly in the cycle after each accepted read and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present; held until accepted |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 12 | Word address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_rdata | output | 32 | Read data |
| cpu_stall | output | 1 | High while a miss or swap is being serviced |
| mem_req_valid | output | 1 | Memory block request present |
| mem_req_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_req_blk | output | 10 | Block address |
| mem_req_wdata | output | 128 | Block data for write-back |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read block returned |
| mem_rsp_rdata | input | 128 | Returned block data |

## Verification
The assertions check the protocol invariants on every cycle. They confirm that memory traffic appears only while the processor is stalled and that a stall starts only after an unserved request. They also confirm that the read response tracks accepted reads exactly and that memory requests hold stable until accepted. Whether a given access should hit, swap with a victim slot or fetch cannot be seen from the handshakes alone. The same applies to which dirty line must be written back, in what order, and what data each read must return. Only the bench's behavioural model of the line array, victim slots and memory can show these, running both directed conflict sequences and a long pseudo-random mix on two heavily contended indices.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWAP,
    ST_EVICT,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_FILL_WR
  } cvb_state_t;
endpackage

// File: rtl/cvb_data_ram.sv
module cvb_data_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cvb_victim_buf.sv
module cvb_victim_buf #(
  parameter int BLK_W   = 10,
  parameter int DATA_W  = 32,
  parameter int WPB     = 4,
  parameter int ENTRIES = 4,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int OFF_W  = $clog2(WPB)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BLK_W-1:0]      look_blk,
  output logic                  look_hit,
  output logic [ENT_W-1:0]      look_idx,
  input  logic [ENT_W-1:0]      rd_idx,
  output logic                  rd_valid,
  output logic                  rd_dirty,
  output logic [BLK_W-1:0]      rd_blk,
  input  logic [OFF_W-1:0]      rd_sel,
  output logic [DATA_W-1:0]     rd_word,
  output logic [WPB*DATA_W-1:0] rd_block,
  input  logic [ENT_W-1:0]      wr_idx,
  input  logic                  meta_we,
  input  logic                  meta_valid,
  input  logic                  meta_dirty,
  input  logic [BLK_W-1:0]      meta_blk,
  input  logic                  word_we,
  input  logic [OFF_W-1:0]      word_sel,
  input  logic [DATA_W-1:0]     word_data,
  input  logic                  ptr_adv,
  output logic [ENT_W-1:0]      ptr
);
  logic [ENTRIES-1:0] e_valid;
  logic [ENTRIES-1:0] e_dirty;
  logic [BLK_W-1:0]   e_blk  [ENTRIES];
  logic [DATA_W-1:0]  e_data [ENTRIES][WPB];
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign match[e] = e_valid[e] && (e_blk[e] == look_blk);
  end

  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) begin
        look_hit = 1'b1;
        look_idx = ENT_W'(e);
      end
    end
  end

  assign rd_valid = e_valid[rd_idx];
  assign rd_dirty = e_dirty[rd_idx];
  assign rd_blk   = e_blk[rd_idx];
  assign rd_word  = e_data[rd_idx][rd_sel];

  for (genvar w = 0; w < WPB; w++) begin : g_blk
    assign rd_block[w*DATA_W +: DATA_W] = e_data[rd_idx][w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
      e_dirty <= '0;
      ptr     <= '0;
      for (int e = 0; e < ENTRIES; e++) e_blk[e] <= '0;
    end else begin
      if (meta_we) begin
        e_valid[wr_idx] <= meta_valid;
        e_dirty[wr_idx] <= meta_dirty;
        e_blk[wr_idx]   <= meta_blk;
      end
      if (ptr_adv) ptr <= (ptr == ENT_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (word_we) e_data[wr_idx][word_sel] <= word_data;
  end
endmodule

// File: rtl/cvb_cache.sv
module cvb_cache
  import cvb_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int DATA_W          = 32,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int LINES           = 8,
  parameter int VICTIMS         = 4,
  localparam int OFF_W  = $clog2(WORDS_PER_BLOCK),
  localparam int IDX_W  = $clog2(LINES),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int TAG_W  = BLK_W - IDX_W,
  localparam int BLKD_W = WORDS_PER_BLOCK * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_stall,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [BLK_W-1:0]  mem_req_blk,
  output logic [BLKD_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [BLKD_W-1:0] mem_rsp_rdata
);
  localparam int CNT_W = OFF_W + 1;
  localparam int ENT_W = $clog2(VICTIMS);
  localparam int RAM_AW = IDX_W + OFF_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORDS_PER_BLOCK);

  cvb_state_t state;

  logic [TAG_W-1:0] line_tag [LINES];
  logic [LINES-1:0] line_valid;
  logic [LINES-1:0] line_dirty;

  logic [IDX_W-1:0]  lat_idx;
  logic [BLK_W-1:0]  lat_blk;
  logic [ENT_W-1:0]  vidx;
  logic [CNT_W-1:0]  cnt;
  logic [BLKD_W-1:0] fill_buf;
  logic              rsp_q;

  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;
  logic [TAG_W-1:0] req_tag;
  logic [BLK_W-1:0] req_blk;
  logic             main_hit;

  assign req_off  = cpu_req_addr[OFF_W-1:0];
  assign req_idx  = cpu_req_addr[OFF_W +: IDX_W];
  assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_blk  = cpu_req_addr[ADDR_W-1:OFF_W];
  assign main_hit = line_valid[req_idx] && (line_tag[req_idx] == req_tag);

  logic [OFF_W-1:0] cnt_lo, cnt_prev;
  assign cnt_lo   = cnt[OFF_W-1:0];
  assign cnt_prev = OFF_W'(cnt - 1'b1);

  // data array
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  cvb_data_ram #(.DW(DATA_W), .DEPTH(LINES * WORDS_PER_BLOCK)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // victim buffer
  logic              vb_hit, vb_rd_valid, vb_rd_dirty;
  logic [ENT_W-1:0]  vb_hit_idx, vb_rd_idx, vb_ptr;
  logic [BLK_W-1:0]  vb_rd_blk, vb_meta_blk;
  logic [DATA_W-1:0] vb_rd_word;
  logic [BLKD_W-1:0] vb_rd_block;
  logic              vb_meta_we, vb_meta_valid, vb_meta_dirty, vb_word_we, vb_ptr_adv;

  cvb_victim_buf #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WPB(WORDS_PER_BLOCK), .ENTRIES(VICTIMS)) u_vb (
    .clk        (clk),
    .rst        (rst),
    .look_blk   (req_blk),
    .look_hit   (vb_hit),
    .look_idx   (vb_hit_idx),
    .rd_idx     (vb_rd_idx),
    .rd_valid   (vb_rd_valid),
    .rd_dirty   (vb_rd_dirty),
    .rd_blk     (vb_rd_blk),
    .rd_sel     (cnt_prev),
    .rd_word    (vb_rd_word),
    .rd_block   (vb_rd_block),
    .wr_idx     (vidx),
    .meta_we    (vb_meta_we),
    .meta_valid (vb_meta_valid),
    .meta_dirty (vb_meta_dirty),
    .meta_blk   (vb_meta_blk),
    .word_we    (vb_word_we),
    .word_sel   (cnt_prev),
    .word_data  (ram_rdata),
    .ptr_adv    (vb_ptr_adv),
    .ptr        (vb_ptr)
  );

  assign vb_rd_idx     = (state == ST_IDLE) ? vb_ptr : vidx;
  assign cpu_req_ready = (state == ST_IDLE) && cpu_req_valid && main_hit;
  assign cpu_stall     = (state != ST_IDLE);
  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = ram_rdata;

  // datapath steering per state
  always_comb begin
    ram_we        = 1'b0;
    ram_waddr     = {req_idx, req_off};
    ram_wdata     = cpu_req_wdata;
    ram_raddr     = {req_idx, req_off};
    vb_word_we    = 1'b0;
    vb_meta_we    = 1'b0;
    vb_meta_valid = line_valid[lat_idx];
    vb_meta_dirty = line_dirty[lat_idx];
    vb_meta_blk   = {line_tag[lat_idx], lat_idx};
    vb_ptr_adv    = 1'b0;
    unique case (state)
      ST_IDLE: ram_we = cpu_req_valid && main_hit && cpu_req_write;
      ST_SWAP: begin
        ram_raddr = {lat_idx, cnt_lo};
        if (cnt != '0) begin
          ram_we     = 1'b1;
          ram_waddr  = {lat_idx, cnt_prev};
          ram_wdata  = vb_rd_word;
          vb_word_we = 1'b1;
        end
        vb_meta_we = (cnt == CNT_LAST);
      end
      ST_EVICT: begin
        ram_raddr     = {lat_idx, cnt_lo};
        vb_word_we    = (cnt != '0);
        vb_meta_we    = (cnt == CNT_LAST);
        vb_meta_valid = 1'b1;
        vb_ptr_adv    = (cnt == CNT_LAST);
      end
      ST_WB: begin
        vb_meta_we    = mem_req_ready;
        vb_meta_valid = vb_rd_valid;
        vb_meta_dirty = 1'b0;
        vb_meta_blk   = vb_rd_blk;
      end
      ST_FILL_WR: begin
        ram_we    = 1'b1;
        ram_waddr = {lat_idx, cnt_lo};
        ram_wdata = fill_buf[cnt_lo*DATA_W +: DATA_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      line_valid    <= '0;
      line_dirty    <= '0;
      for (int l = 0; l < LINES; l++) line_tag[l] <= '0;
      lat_idx       <= '0;
      lat_blk       <= '0;
      vidx          <= '0;
      cnt           <= '0;
      fill_buf      <= '0;
      rsp_q         <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_blk   <= '0;
      mem_req_wdata <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (cpu_req_valid) begin
          if (main_hit) begin
            if (cpu_req_write) line_dirty[req_idx] <= 1'b1;
            else               rsp_q <= 1'b1;
          end else begin
            lat_idx <= req_idx;
            lat_blk <= req_blk;
            cnt     <= '0;
            if (vb_hit) begin
              vidx  <= vb_hit_idx;
              state <= ST_SWAP;
            end else begin
              vidx <= vb_ptr;
              if (vb_rd_valid && vb_rd_dirty) begin
                mem_req_valid <= 1'b1;
                mem_req_write <= 1'b1;
                mem_req_blk   <= vb_rd_blk;
                mem_req_wdata <= vb_rd_block;
                state         <= ST_WB;
              end else if (line_valid[req_idx]) begin
                state <= ST_EVICT;
              end else begin
                mem_req_valid <= 1'b1;
                mem_req_write <= 1'b0;
                mem_req_blk   <= req_blk;
                state         <= ST_FILL_REQ;
              end
            end
          end
        end
        ST_SWAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            line_tag[lat_idx]   <= vb_rd_blk[BLK_W-1:IDX_W];
            line_valid[lat_idx] <= 1'b1;
            line_dirty[lat_idx] <= vb_rd_dirty;
            state               <= ST_IDLE;
          end
        end
        ST_EVICT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b0;
            mem_req_blk   <= lat_blk;
            state         <= ST_FILL_REQ;
          end
        end
        ST_WB: if (mem_req_ready) begin
          cnt <= '0;
          if (line_valid[lat_idx]) begin
            mem_req_valid <= 1'b0;
            state         <= ST_EVICT;
          end else begin
            mem_req_write <= 1'b0;
            mem_req_blk   <= lat_blk;
            state         <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state         <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          fill_buf <= mem_rsp_rdata;
          cnt      <= '0;
          state    <= ST_FILL_WR;
        end
        ST_FILL_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(WORDS_PER_BLOCK - 1)) begin
            line_tag[lat_idx]   <= lat_blk[BLK_W-1:IDX_W];
            line_valid[lat_idx] <= 1'b1;
            line_dirty[lat_idx] <= 1'b0;
            state               <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cvb_cache_chk.sv
module cvb_cache_chk #(
  parameter int BLK_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_req_valid,
  input logic             cpu_req_write,
  input logic             cpu_req_ready,
  input logic             cpu_rsp_valid,
  input logic             cpu_stall,
  input logic             mem_req_valid,
  input logic             mem_req_write,
  input logic [BLK_W-1:0] mem_req_blk,
  input logic             mem_req_ready
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cpu_stall && !mem_req_valid && !cpu_rsp_valid));

  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> cpu_stall);

  assert_stall_after_miss_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |-> $past(cpu_req_valid && !cpu_req_ready));

  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_blk) && $stable(mem_req_write)));

  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && !cpu_req_write) |=> cpu_rsp_valid);

  assert_rsp_only_after_read_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready && !cpu_req_write));
endmodule

bind cvb_cache cvb_cache_chk #(.BLK_W(BLK_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_write (cpu_req_write),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_stall     (cpu_stall),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .mem_req_blk   (mem_req_blk),
  .mem_req_ready (mem_req_ready)
);

// File: tb/cvb_cache_test.sv
module cvb_cache_test;
  localparam int AW = 12, DW = 32, WPB = 4, NL = 8, NV = 4;
  localparam int BW = AW - 2;
  localparam int NWORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              cpu_req_valid = 0, cpu_req_write = 0;
  logic [AW-1:0]     cpu_req_addr = '0;
  logic [DW-1:0]     cpu_req_wdata = '0;
  logic              cpu_req_ready, cpu_rsp_valid, cpu_stall;
  logic [DW-1:0]     cpu_rsp_rdata;
  logic              mem_req_valid, mem_req_write;
  logic [BW-1:0]     mem_req_blk;
  logic [WPB*DW-1:0] mem_req_wdata;
  logic              mem_req_ready = 0, mem_rsp_valid = 0;
  logic [WPB*DW-1:0] mem_rsp_rdata = '0;

  cvb_cache uut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_stall(cpu_stall),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_blk(mem_req_blk), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  typedef struct {
    bit              wr;
    int              blk;
    logic [WPB*DW-1:0] d;
  } ev_t;

  ev_t exp_q[$];
  ev_t act_q[$];

  int n_checks = 0, n_fail = 0;
  int n_mem_wr = 0, n_mem_rd = 0, last_rd_blk = -1;
  bit finished = 0;

  logic [DW-1:0] bmem [NWORDS];
  logic [DW-1:0] mmem [NWORDS];

  // behavioural model of lines and victim slots
  bit            m_valid [NL];
  bit            m_dirty [NL];
  int            m_blk   [NL];
  logic [DW-1:0] m_data  [NL][WPB];
  bit            v_valid [NV];
  bit            v_dirty [NV];
  int            v_blk   [NV];
  logic [DW-1:0] v_data  [NV][WPB];
  int            v_ptr = 0;

  task automatic check(bit ok, string req, string what, logic [WPB*DW-1:0] act, logic [WPB*DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  function automatic logic [WPB*DW-1:0] pack_v(int k);
    logic [WPB*DW-1:0] r;
    for (int w = 0; w < WPB; w++) r[w*DW +: DW] = v_data[k][w];
    return r;
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        ev_t ev;
        ev.wr  = mem_req_write;
        ev.blk = int'(mem_req_blk);
        ev.d   = mem_req_write ? mem_req_wdata : '0;
        @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        act_q.push_back(ev);
        if (ev.wr) begin
          n_mem_wr++;
          for (int w = 0; w < WPB; w++) bmem[ev.blk*WPB + w] = ev.d[w*DW +: DW];
        end else begin
          n_mem_rd++;
          last_rd_blk = ev.blk;
          @(negedge clk);
          for (int w = 0; w < WPB; w++) mem_rsp_rdata[w*DW +: DW] = bmem[ev.blk*WPB + w];
          mem_rsp_valid = 1'b1;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  // one processor access, predicted by the model and checked at the ports
  task automatic access(bit wr, int addr, logic [DW-1:0] wd, output logic [DW-1:0] got);
    int blk, idx, off, cls, k, p, waits;
    ev_t e;
    string tag;
    logic [DW-1:0] exp_rd;
    blk = addr >> 2; idx = blk % NL; off = addr % WPB;
    cls = 2; k = -1;
    if (m_valid[idx] && m_blk[idx] == blk) cls = 0;
    else begin
      for (int j = 0; j < NV; j++) if (v_valid[j] && v_blk[j] == blk) k = j;
      if (k >= 0) cls = 1;
    end
    if (cls == 1) begin
      bit tv, td; int tb; logic [DW-1:0] t;
      tv = m_valid[idx]; td = m_dirty[idx]; tb = m_blk[idx];
      m_valid[idx] = 1; m_dirty[idx] = v_dirty[k]; m_blk[idx] = v_blk[k];
      v_valid[k] = tv; v_dirty[k] = td; v_blk[k] = tb;
      for (int w = 0; w < WPB; w++) begin
        t = m_data[idx][w]; m_data[idx][w] = v_data[k][w]; v_data[k][w] = t;
      end
    end else if (cls == 2) begin
      p = v_ptr;
      if (v_valid[p] && v_dirty[p]) begin
        e.wr = 1; e.blk = v_blk[p]; e.d = pack_v(p);
        exp_q.push_back(e);
        for (int w = 0; w < WPB; w++) mmem[v_blk[p]*WPB + w] = v_data[p][w];
        v_dirty[p] = 0;
      end
      if (m_valid[idx]) begin
        v_valid[p] = 1; v_dirty[p] = m_dirty[idx]; v_blk[p] = m_blk[idx];
        for (int w = 0; w < WPB; w++) v_data[p][w] = m_data[idx][w];
        v_ptr = (p + 1) % NV;
      end
      e.wr = 0; e.blk = blk; e.d = '0;
      exp_q.push_back(e);
      m_valid[idx] = 1; m_dirty[idx] = 0; m_blk[idx] = blk;
      for (int w = 0; w < WPB; w++) m_data[idx][w] = mmem[blk*WPB + w];
    end
    if (wr) begin
      m_data[idx][off] = wd;
      m_dirty[idx] = 1;
    end
    exp_rd = m_data[idx][off];
    tag = (cls == 0) ? "R3" : (cls == 1) ? "R7" : "R8";

    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = AW'(addr); cpu_req_wdata = wd;
    #1;
    waits = 0;
    while (!cpu_req_ready) begin
      @(negedge clk); #1; waits++;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 0;
    #1;
    got = cpu_rsp_rdata;
    if (cls == 0) check(waits == 0, "R3", "hit accepted without stall", waits, 0);
    else          check(waits > 0, "R4", "miss stalls before acceptance", waits, 1);
    if (!wr) check(cpu_rsp_valid === 1'b1 && cpu_rsp_rdata === exp_rd,
                   (cls == 1) ? "R7" : (cls == 2) ? "R4" : "R3", "read data", cpu_rsp_rdata, exp_rd);
    else check(cpu_rsp_valid === 1'b0, "R10", "no response for write", cpu_rsp_valid, 0);
    check(act_q.size() == exp_q.size(), tag, "memory transfer count", act_q.size(), exp_q.size());
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      ev_t a, x;
      a = act_q.pop_front(); x = exp_q.pop_front();
      check(a.wr == x.wr && a.blk == x.blk && a.d === x.d, tag,
            $sformatf("transfer wr=%0d blk=%0d vs wr=%0d blk=%0d", a.wr, a.blk, x.wr, x.blk), a.d, x.d);
    end
    act_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R4 watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    int wr0, rd0;
    logic [15:0] lfsr;
    for (int i = 0; i < NWORDS; i++) begin
      bmem[i] = 32'hC000_0000 ^ (i * 32'h0001_0003);
      mmem[i] = bmem[i];
    end
    for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_blk[i] = 0; end
    for (int i = 0; i < NV; i++) begin v_valid[i] = 0; v_dirty[i] = 0; v_blk[i] = 0; end

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    check(!cpu_stall && !mem_req_valid && !cpu_rsp_valid, "R1", "quiet after reset",
          {cpu_stall, mem_req_valid, cpu_rsp_valid}, 0);

    // cold miss, address split
    access(0, 12'h000, 0, got);
    check(last_rd_blk == 0 && n_mem_rd == 1, "R1", "cold access fetches block", last_rd_blk, 0);
    access(0, 12'h027, 0, got);
    check(last_rd_blk == 9, "R2", "block address is addr>>2", last_rd_blk, 9);
    access(0, 12'h001, 0, got);

    // write hit stays in cache
    wr0 = n_mem_wr;
    access(1, 12'h002, 32'hDEAD_BEEF, got);
    check(n_mem_wr == wr0, "R5", "write hit no memory write", n_mem_wr, wr0);
    access(0, 12'h002, 0, got);
    check(got == 32'hDEAD_BEEF, "R5", "write hit readback", got, 32'hDEAD_BEEF);

    // write miss allocates
    access(1, 12'h045, 32'h1234_5678, got);
    access(0, 12'h045, 0, got);
    check(got == 32'h1234_5678, "R5", "write miss merged word", got, 32'h1234_5678);
    access(0, 12'h046, 0, got);
    check(got == mmem[12'h046], "R5", "write miss other words fetched", got, mmem[12'h046]);

    // conflict on index 0: dirty line goes to a victim slot, not memory
    wr0 = n_mem_wr;
    access(0, 12'h020, 0, got);
    check(n_mem_wr == wr0, "R6", "eviction writes nothing", n_mem_wr, wr0);

    // victim hit returns the dirty word with no memory traffic
    rd0 = n_mem_rd;
    access(0, 12'h002, 0, got);
    check(got == 32'hDEAD_BEEF && n_mem_rd == rd0, "R7", "victim swap data", got, 32'hDEAD_BEEF);

    // cycle the buffer on index 0 until the dirty line is written back
    wr0 = n_mem_wr;
    for (int b = 2; b < 8; b++) access(0, b * 32, 0, got);
    check(n_mem_wr > wr0, "R8", "dirty slot written back on reuse", n_mem_wr, wr0 + 1);

    // pseudo-random mix on two contended indices
    lfsr = 16'hACE1;
    for (int n = 0; n < 500; n++) begin
      int blk, a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      blk = (int'(lfsr[2:0]) % 6) * 8 + int'(lfsr[3]);
      a = blk * 4 + int'(lfsr[5:4]);
      access(lfsr[6] & lfsr[8], a, {lfsr, lfsr ^ 16'h5A5A}, got);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule